// File: doc/BRIEF.md
# Power-Good Strap Sampling Sequencer

This block controls how a clock generator starts up. When reset ends, the clock outputs are off. The block then waits for an active-low power-good strobe. When that strobe goes low, the block runs a settling delay counted in ticks of a timebase. At the end of the delay it latches the frequency-select straps and the current-multiplier strap once, starts the VCO and then enables the clock outputs. The delay hides glitches on the strobe and on the straps while the supplies ramp.

One select strap has three levels. An analog comparator outside this block decodes it into a two-bit code. The other two selects and the multiplier strap are plain binary. After the strobe has been seen low, the block ignores the strobe and the straps until the next reset. The latched values stay on the outputs and do not change.

The delay length is set by parameters: the reference tick rate in kHz and the delay in microseconds. The defaults give a delay of about 0.25 ms at a 14.318 MHz reference.

Top module: `pwrgd_strap_seq`

## Requirements
- R1: While reset is asserted, `seq_state` is 2'b00 (clocks off), `vco_en` and `clk_oe` are 0, and every latched strap output is 0.
- R2: After reset is released through the two-stage synchronizer, the sequencer leaves the clocks-off state on the next clock and enters the waiting state (2'b01). It stays there while `pg_n` is high, whatever `tick` does.
- R3: A low on `pg_n` passes through a two-flop synchronizer. The sequencer enters the delaying state (2'b10) on the third rising edge after `pg_n` is first seen low.
- R4: The delaying state lasts exactly DELAY_TICKS = REF_KHZ*DELAY_US/1000 `tick` pulses. The sequencer enters the clocks-on state (2'b11) on the clock edge that samples the last of these ticks.
- R5: The straps are captured on that same edge. The three-level code is 2'b00 for low, 2'b01 for mid and 2'b10 for high, and the unused code 2'b11 is stored as mid. The binary selects and the multiplier strap are stored as they are.
- R6: `strap_view[2]` is 1 only when the latched three-level strap is high. `strap_view[1:0]` repeat the two latched binary selects.
- R7: `vco_en` is 1 exactly while the sequencer is in the clocks-on state.
- R8: `clk_oe` rises one clock after the clocks-on state is entered and stays at 1 until reset.
- R9: Once the delaying state has been entered, changes on `pg_n` and on the straps have no effect until reset. The state only moves forward, and the latched values do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n_in | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pg_n | input | 1 | Power-good strobe, active low, asynchronous |
| tick | input | 1 | Timebase pulse, one clock wide, counted during the delay |
| sel_tri | input | 2 | Pre-decoded three-level strap: 00 low, 01 mid, 10 high |
| sel_bin | input | 2 | Two binary frequency-select straps |
| mult_in | input | 1 | Current-multiplier strap |
| tri_held | output | 2 | Latched three-level code |
| bin_held | output | 2 | Latched binary selects |
| mult_held | output | 1 | Latched multiplier strap |
| strap_view | output | 3 | Status bits: high-level flag of the three-level strap, then the binary selects |
| vco_en | output | 1 | VCO enable |
| clk_oe | output | 1 | Clock output enable |
| seq_state | output | 2 | Sequencer state: 00 off, 01 waiting, 10 delaying, 11 on |

## Verification
Assertions check every cycle that the state only moves forward once delaying has begun, that `vco_en` matches the clocks-on state, that `clk_oe` only rises after a cycle in the clocks-on state, that the delay counter stays in range, and that latched straps never change after capture. Only the bench scenarios can show the exact latency through the synchronizers, that the delay is exactly DELAY_TICKS ticks long, and that the captured value is the strap value on the final tick. They also show that each of the 32 strap combinations, including the unused three-level code, is stored and reported correctly.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'b00,
    ST_WAIT  = 2'b01,
    ST_DELAY = 2'b10,
    ST_ON    = 2'b11
  } seq_state_e;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10
  } tri_lvl_e;

  typedef struct packed {
    tri_lvl_e   lvl;
    logic [1:0] bin;
    logic       mult;
  } strap_t;

  // Fold the unused comparator code onto the mid level.
  function automatic tri_lvl_e fold_tri(input logic [1:0] code);
    if (code == 2'b11) return LVL_MID;
    return tri_lvl_e'(code);
  endfunction

endpackage

// File: rtl/pgs_sync.sv
module pgs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RST_VAL;
          else        chain_q[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= RST_VAL;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/pgs_settle_timer.sv
module pgs_settle_timer #(
  parameter int DELAY_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic done
);

  localparam int CW = (DELAY_TICKS < 2) ? 1 : $clog2(DELAY_TICKS);
  localparam logic [CW-1:0] LAST = CW'(DELAY_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done   = run && tick && (cnt_q == LAST);
  assign cnt_en = !run || tick;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)       cnt_d = '0;
    else if (done)  cnt_d = '0;
    else            cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R4

  AST_CNT_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/pgs_strap_latch.sv
module pgs_strap_latch
  import pgs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capture,
  input  logic [1:0] tri_in,
  input  logic [1:0] bin_in,
  input  logic       mult_in,
  output strap_t     held,
  output logic [2:0] view
);

  strap_t held_q, held_d;
  logic   taken_q;

  always_comb begin
    held_d.lvl  = fold_tri(tri_in);
    held_d.bin  = bin_in;
    held_d.mult = mult_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= '0;
      taken_q <= 1'b0;
    end else if (capture) begin
      held_q  <= held_d;
      taken_q <= 1'b1;
    end
  end

  assign held = held_q;
  assign view = {held_q.lvl == LVL_HIGH, held_q.bin};

  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    taken_q |=> $stable(held_q)); // R9

  AST_SINGLE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !taken_q); // R9

  AST_NO_RAW_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    held_q.lvl != 2'b11); // R5

endmodule

// File: rtl/pwrgd_strap_seq.sv
module pwrgd_strap_seq
  import pgs_pkg::*;
#(
  parameter int REF_KHZ  = 14318,
  parameter int DELAY_US = 250,
  parameter int SYNC_STG = 2
) (
  input  logic       clk,
  input  logic       rst_n_in,
  input  logic       pg_n,
  input  logic       tick,
  input  logic [1:0] sel_tri,
  input  logic [1:0] sel_bin,
  input  logic       mult_in,
  output logic [1:0] tri_held,
  output logic [1:0] bin_held,
  output logic       mult_held,
  output logic [2:0] strap_view,
  output logic       vco_en,
  output logic       clk_oe,
  output logic [1:0] seq_state
);

  localparam int RAW_TICKS   = (REF_KHZ * DELAY_US) / 1000;
  localparam int DELAY_TICKS = (RAW_TICKS < 1) ? 1 : RAW_TICKS;

  logic       rst_n;
  logic       pg_n_s;
  logic       timer_done;
  logic       capture;
  seq_state_e state_q, state_d;
  logic       vco_q, vco_d;
  logic       oe_q, oe_d;
  strap_t     held;

  pgs_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n_in), .d(1'b1), .q(rst_n)
  );

  pgs_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_pg_sync (
    .clk(clk), .rst_n(rst_n), .d(pg_n), .q(pg_n_s)
  );

  pgs_settle_timer #(.DELAY_TICKS(DELAY_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_DELAY),
    .tick(tick), .done(timer_done)
  );

  assign capture = (state_q == ST_DELAY) && timer_done;

  pgs_strap_latch u_latch (
    .clk(clk), .rst_n(rst_n), .capture(capture),
    .tri_in(sel_tri), .bin_in(sel_bin), .mult_in(mult_in),
    .held(held), .view(strap_view)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:   state_d = ST_WAIT;
      ST_WAIT:  if (!pg_n_s)   state_d = ST_DELAY;
      ST_DELAY: if (timer_done) state_d = ST_ON;
      ST_ON:    state_d = ST_ON;
      default:  state_d = ST_OFF;
    endcase
  end

  always_comb begin
    vco_d = vco_q || capture;
    oe_d  = oe_q  || (state_q == ST_ON);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      vco_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      vco_q   <= vco_d;
      oe_q    <= oe_d;
    end
  end

  assign tri_held  = held.lvl;
  assign bin_held  = held.bin;
  assign mult_held = held.mult;
  assign vco_en    = vco_q;
  assign clk_oe    = oe_q;
  assign seq_state = state_q;

  AST_VCO_MATCH_ON: assert property (@(posedge clk) disable iff (!rst_n)
    vco_q == (state_q == ST_ON)); // R7

  AST_OE_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(state_q) == ST_ON); // R8

  AST_OE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |=> oe_q); // R8

  AST_ON_TERMINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ON) |=> (state_q == ST_ON)); // R9

  AST_DELAY_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DELAY) |=> (state_q == ST_DELAY || state_q == ST_ON)); // R9

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && pg_n_s) |=> (state_q == ST_WAIT)); // R2

endmodule

// File: tb/sim_pwrgd_strap_seq.sv
module sim_pwrgd_strap_seq;

  localparam int REF_KHZ  = 4;
  localparam int DELAY_US = 1000;
  localparam int N_TICKS  = REF_KHZ * DELAY_US / 1000;

  logic       clk = 1'b0;
  logic       rst_n_in;
  logic       pg_n;
  logic       tick;
  logic [1:0] sel_tri;
  logic [1:0] sel_bin;
  logic       mult_in;
  logic [1:0] tri_held;
  logic [1:0] bin_held;
  logic       mult_held;
  logic [2:0] strap_view;
  logic       vco_en;
  logic       clk_oe;
  logic [1:0] seq_state;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pwrgd_strap_seq #(.REF_KHZ(REF_KHZ), .DELAY_US(DELAY_US)) u0 (
    .clk(clk), .rst_n_in(rst_n_in), .pg_n(pg_n), .tick(tick),
    .sel_tri(sel_tri), .sel_bin(sel_bin), .mult_in(mult_in),
    .tri_held(tri_held), .bin_held(bin_held), .mult_held(mult_held),
    .strap_view(strap_view), .vco_en(vco_en), .clk_oe(clk_oe),
    .seq_state(seq_state)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic one_tick();
    tick = 1'b1;
    step();
    tick = 1'b0;
    step();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    rst_n_in = 1'b0;
    pg_n = 1'b1; tick = 1'b0;
    sel_tri = 2'b00; sel_bin = 2'b00; mult_in = 1'b0;
    for (int t = 0; t < 4; t++) begin
      for (int b = 0; b < 4; b++) begin
        for (int m = 0; m < 2; m++) begin
          int exp_tri;
          exp_tri = (t == 3) ? 1 : t;
          // reset state
          rst_n_in = 1'b0; pg_n = 1'b1; tick = 1'b0;
          sel_tri = 2'(t); sel_bin = 2'(b); mult_in = m[0];
          step(); step();
          check("R1 state", seq_state, 0);
          check("R1 vco_en", vco_en, 0);
          check("R1 clk_oe", clk_oe, 0);
          check("R1 held", {tri_held, bin_held, mult_held}, 0);
          // release reset: two sync edges, then off -> wait
          rst_n_in = 1'b1;
          step(); step();
          check("R2 still off", seq_state, 0);
          step();
          check("R2 wait", seq_state, 1);
          // ticks while power-good high are ignored
          for (int k = 0; k < N_TICKS + 2; k++) one_tick();
          check("R2 wait with ticks", seq_state, 1);
          // strobe low: visible on third edge
          pg_n = 1'b0;
          step(); step();
          check("R3 sync latency", seq_state, 1);
          step();
          check("R3 delaying", seq_state, 2);
          // garbage straps and strobe bounce during delay
          sel_tri = ~2'(t); sel_bin = ~2'(b); mult_in = ~m[0];
          for (int k = 0; k < N_TICKS - 1; k++) begin
            pg_n = k[0];
            one_tick();
          end
          check("R4 not yet on", seq_state, 2);
          check("R7 vco off in delay", vco_en, 0);
          // final tick with target straps
          sel_tri = 2'(t); sel_bin = 2'(b); mult_in = m[0];
          tick = 1'b1;
          step();
          tick = 1'b0;
          check("R4 on after last tick", seq_state, 3);
          check("R7 vco on", vco_en, 1);
          check("R8 oe not yet", clk_oe, 0);
          check("R5 tri", tri_held, exp_tri);
          check("R5 bin", bin_held, b);
          check("R5 mult", mult_held, m);
          check("R6 view", strap_view, {exp_tri == 2 ? 1 : 0, b[1:0]});
          step();
          check("R8 oe on", clk_oe, 1);
          // everything after capture ignored
          sel_tri = ~2'(t); sel_bin = ~2'(b); mult_in = ~m[0];
          pg_n = 1'b1;
          one_tick();
          pg_n = 1'b0;
          one_tick();
          check("R9 state held", seq_state, 3);
          check("R9 tri held", tri_held, exp_tri);
          check("R9 bin held", bin_held, b);
          check("R9 mult held", mult_held, m);
          check("R8 oe sticky", clk_oe, 1);
        end
      end
    end
    summary();
  end

endmodule